// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block produces the reset for a processor from digitized supply-monitor flags and a watchdog. A flag that says the supply is under its trip point, or a flag that says the supply has dropped beneath the backup battery, pulls the reset low almost at once. Reset is then held for a fixed stretch after both flags have cleared. A watchdog counts time-base ticks. When software fails to service it within the current period, the watchdog fires a reset pulse of the same stretch length. It keeps doing so for every further period that passes without service.

The watchdog period is picked by a select input: long, or short. The first period after any reset, whatever its cause, is always the long one. The select input only takes effect once software has serviced the watchdog. A chip-select from the address decoder is passed through while the supply is healthy and forced inactive while it is not. Two status outputs report the supply condition: a supply-good flag and a running-from-backup flag.

All time is counted in ticks of a single-cycle enable pulse from a prescaled time base. The supply flags, the service strobe and the select input are asynchronous and pass through two-flop synchronizers.

Top module: `sup_rst_wdog`

## Requirements
- R1: Within three clock cycles of either supply flag (low supply, or supply below battery) going high, `cpu_rst_n_o` goes low. It stays low for as long as either flag is high.
- R2: Once both supply flags have cleared, `cpu_rst_n_o` returns high on the STRETCH_TICKS-th tick that follows.
- R3: An unserviced watchdog period ends in a reset pulse that lasts STRETCH_TICKS ticks. Every later unserviced period repeats this.
- R4: After a service, the watchdog fires on the SHORT_TICKS-th tick that follows when `short_sel_i` is 1, and on the LONG_TICKS-th tick when it is 0.
- R5: After any reset is released, the watchdog fires on the LONG_TICKS-th tick unless it is serviced, whatever `short_sel_i` says.
- R6: A service is a rising edge on `service_i`. It restarts the watchdog period. A falling edge does nothing, and a rising edge while reset is asserted does not shorten the reset pulse.
- R7: `cpu_rst_o` is always the inverse of `cpu_rst_n_o`.
- R8: `cs_n_o` equals `cs_n_i` while both synchronized supply flags are clear, and is 1 (inactive) while either flag is set.
- R9: `supply_good_o` is 0 while either synchronized supply flag is set, and 1 otherwise.
- R10: `backup_o` is 1 while the synchronized supply-below-battery flag is set, and 0 otherwise.
- R11: While `rst_n` is low, `cpu_rst_n_o` is 0. After `rst_n` rises, `cpu_rst_n_o` goes high on the STRETCH_TICKS-th tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle time-base enable |
| supply_low_i | input | 1 | Asynchronous flag: supply under its trip point |
| below_batt_i | input | 1 | Asynchronous flag: supply under the battery voltage |
| service_i | input | 1 | Asynchronous watchdog service strobe |
| short_sel_i | input | 1 | Watchdog period select: 1 = short, 0 = long |
| cs_n_i | input | 1 | Active-low chip select from the decoder |
| cpu_rst_n_o | output | 1 | Active-low processor reset |
| cpu_rst_o | output | 1 | Active-high processor reset |
| cs_n_o | output | 1 | Gated active-low chip select |
| supply_good_o | output | 1 | 1 when neither supply flag is set |
| backup_o | output | 1 | 1 while the rail runs from the battery |

## Verification
The assertions assume that `tick_i` is a single-cycle pulse spaced wider than the three-cycle synchronizer and reset latency. They also assume the asynchronous inputs hold each level for at least two clocks, so every change survives the synchronizers. The stimulus raises ticks every eight clocks. It changes every asynchronous input only on the falling clock edge just after a tick has been consumed, and holds each level for at least one whole tick. As a result, each reset edge falls inside a known tick interval, and the scoreboard can expect it at an exact tick count.

// File: rtl/sup_rst_pkg.sv
// Package: shared types for the supervisory reset controller.
// Assumes: the field order of the bundle matches the concatenation in the top.
package sup_rst_pkg;

    // Asynchronous inputs that share one synchronizer bank.
    typedef struct packed {
        logic supply_low;
        logic below_batt;
        logic service;
        logic short_sel;
    } async_bundle_t;

endpackage

// File: rtl/sup_sync2.sv
// Module: two-flop synchronizer bank, one chain per bit.
// Assumes: each bit is independent; inputs hold for at least two clocks.
module sup_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [1:0] ff_q;
        // Shift the asynchronous bit through two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) ff_q <= 2'b00;
            else        ff_q <= {ff_q[0], d[i]};
        end
        assign q[i] = ff_q[1];
    end
endmodule

// File: rtl/sup_stretch.sv
// Module: reset pulse stretcher.
// A level cause (hold) or a one-cycle cause (pulse) loads the counter and
// asserts reset. Reset is released on the STRETCH_TICKS-th tick after the
// last cause. Block reset powers up asserted with the counter loaded.
// Assumes: STRETCH_TICKS >= 1; tick is a one-cycle enable.
module sup_stretch #(
    parameter int STRETCH_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold,
    input  logic pulse,
    output logic active
);
    localparam int CW = $clog2(STRETCH_TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(STRETCH_TICKS);

    logic [CW-1:0] cnt_q;
    logic          active_q;

    // Load on any cause; count ticks down and release at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b1;
            cnt_q    <= LOAD;
        end else if (hold || pulse) begin
            active_q <= 1'b1;
            cnt_q    <= LOAD;
        end else if (active_q && tick) begin
            if (cnt_q <= CW'(1)) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    assign active = active_q;

    // A held supply cause always leaves reset asserted.
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> active_q);
    // A watchdog pulse always starts a reset pulse.
    assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> active_q);
    // Release happens only on a tick and never while a cause is present.
    assert_release_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_q) |-> ($past(tick) && !$past(hold) && !$past(pulse)));
endmodule

// File: rtl/sup_wdog.sv
// Module: watchdog period counter.
// Counts ticks while reset is released. The expire pulse fires on the
// limit-th tick. A service rising edge restarts the count and enables the
// selected period. Reset forces the long period until the next service.
// Assumes: SHORT_TICKS <= LONG_TICKS; both >= 1.
module sup_wdog #(
    parameter int LONG_TICKS  = 1600,
    parameter int SHORT_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic service_rise,
    input  logic short_sel,
    input  logic rst_active,
    output logic expire
);
    localparam int CW = $clog2(LONG_TICKS + 1);
    localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_TICKS);
    localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_TICKS);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;
    logic          long_q;
    logic          expire_q;

    // Pick the active period: long after reset, else per select.
    always_comb limit = (long_q || !short_sel) ? LONG_LIM : SHORT_LIM;

    // Clear while reset is active, restart on service, else count ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            long_q   <= 1'b1;
            expire_q <= 1'b0;
        end else begin
            expire_q <= 1'b0;
            if (rst_active) begin
                cnt_q  <= '0;
                long_q <= 1'b1;
            end else if (service_rise) begin
                cnt_q  <= '0;
                long_q <= 1'b0;
            end else if (tick) begin
                if (cnt_q >= limit - CW'(1)) begin
                    expire_q <= 1'b1;
                    cnt_q    <= '0;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end

    assign expire = expire_q;

    // The first period after a reset is always the long one.
    assert_long_after_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_active) |-> long_q);
    // An accepted service restarts the count from zero.
    assert_service_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (service_rise && !rst_active) |=> (cnt_q == '0 && !expire_q));
    // No expiry is produced while reset is being held.
    assert_quiet_in_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active |=> !expire_q);
endmodule

// File: rtl/sup_rst_wdog.sv
// Module: supervisory reset and watchdog controller (top).
// Synchronizes the supply flags, the service strobe and the select input.
// Stretches reset after a supply fault or a watchdog expiry, gates the chip
// select and reports the supply state.
// Assumes: tick_i is a one-cycle pulse spaced wider than three clocks.
module sup_rst_wdog #(
    parameter int STRETCH_TICKS = 200,
    parameter int LONG_TICKS    = 1600,
    parameter int SHORT_TICKS   = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic supply_low_i,
    input  logic below_batt_i,
    input  logic service_i,
    input  logic short_sel_i,
    input  logic cs_n_i,
    output logic cpu_rst_n_o,
    output logic cpu_rst_o,
    output logic cs_n_o,
    output logic supply_good_o,
    output logic backup_o
);
    import sup_rst_pkg::*;

    async_bundle_t raw_in;
    async_bundle_t syn_in;
    logic          supply_fail;
    logic          service_prev_q;
    logic          service_rise;
    logic          rst_active;
    logic          wd_expire;

    assign raw_in = {supply_low_i, below_batt_i, service_i, short_sel_i};

    sup_sync2 #(.WIDTH($bits(async_bundle_t))) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    assign supply_fail = syn_in.supply_low | syn_in.below_batt;

    // Remember the previous synchronized service level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) service_prev_q <= 1'b0;
        else        service_prev_q <= syn_in.service;
    end
    assign service_rise = syn_in.service & ~service_prev_q;

    sup_stretch #(.STRETCH_TICKS(STRETCH_TICKS)) u_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_i),
        .hold   (supply_fail),
        .pulse  (wd_expire),
        .active (rst_active)
    );

    sup_wdog #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_wdog (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick_i),
        .service_rise (service_rise),
        .short_sel    (syn_in.short_sel),
        .rst_active   (rst_active),
        .expire       (wd_expire)
    );

    assign cpu_rst_o     = rst_active;
    assign cpu_rst_n_o   = ~rst_active;
    assign cs_n_o        = supply_fail ? 1'b1 : cs_n_i;
    assign supply_good_o = ~supply_fail;
    assign backup_o      = syn_in.below_batt;

    // Chip select is blocked whenever the supply is reported bad.
    assert_cs_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_good_o |-> cs_n_o);
    // Running from battery always implies the supply is reported bad.
    assert_backup_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        backup_o |-> !supply_good_o);
    // A bad supply always comes with an asserted processor reset.
    assert_fault_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_good_o |=> !cpu_rst_n_o);
endmodule

// File: tb/sup_rst_wdog_tb.sv
// Bench: scoreboard of expected reset edges, with the tick index of each.
module sup_rst_wdog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV = 8;
    localparam int ST   = 5;
    localparam int LG   = 16;
    localparam int SH   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic supply_low = 1'b0, below_batt = 1'b0, service = 1'b0, short_sel = 1'b1, cs_n = 1'b1;
    logic cpu_rst_n, cpu_rst, cs_n_gated, supply_good, backup;

    sup_rst_wdog #(.STRETCH_TICKS(ST), .LONG_TICKS(LG), .SHORT_TICKS(SH)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .supply_low_i(supply_low),
        .below_batt_i(below_batt), .service_i(service), .short_sel_i(short_sel),
        .cs_n_i(cs_n), .cpu_rst_n_o(cpu_rst_n), .cpu_rst_o(cpu_rst),
        .cs_n_o(cs_n_gated), .supply_good_o(supply_good), .backup_o(backup)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    int tick_n = 0;
    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    typedef struct {
        bit    lvl;
        int    at;
        string req;
    } ev_t;
    ev_t exp_q[$];

    // Time base: one tick every TDIV clocks, driven on falling edges.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc % TDIV == 0) begin
                tick = 1'b1;
                tick_n++;
            end else begin
                tick = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push(input bit lvl, input int at, input string req);
        ev_t e;
        e.lvl = lvl; e.at = at; e.req = req;
        exp_q.push_back(e);
    endtask

    // Return on the falling edge just after a tick was consumed.
    task automatic next_tick(output int k);
        do @(posedge clk); while (tick !== 1'b1);
        k = tick_n;
        @(negedge clk);
    endtask

    task automatic until_tick(input int t);
        int k;
        k = -1;
        while (k < t) next_tick(k);
    endtask

    // Monitor: pops one expected edge per observed reset edge.
    initial begin
        logic prev;
        prev = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            if (mon_en) begin
                if (cpu_rst !== ~cpu_rst_n)
                    chk(1'b0, "R7", "complement", int'(cpu_rst), int'(~cpu_rst_n));
                if (cpu_rst_n !== prev) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R3", "unexpected reset edge at tick", tick_n, -1);
                    end else begin
                        ev_t e;
                        e = exp_q.pop_front();
                        chk(cpu_rst_n == e.lvl, e.req, "reset level", int'(cpu_rst_n), int'(e.lvl));
                        chk(tick_n == e.at, e.req, "reset edge tick", tick_n, e.at);
                    end
                    prev = cpu_rst_n;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver: applies stimulus and pushes the edges it expects.
    initial begin
        int k0, t, f, r, r2, r3, r4, r5;
        repeat (5) @(negedge clk);
        // R11 / R7: reset state.
        chk(cpu_rst_n == 1'b0, "R11", "rst_n_o in reset", int'(cpu_rst_n), 0);
        chk(cpu_rst == 1'b1, "R7", "rst_o in reset", int'(cpu_rst), 1);
        chk(backup == 1'b0, "R10", "backup in reset", int'(backup), 0);
        next_tick(k0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        // R11 power-up stretch, R5 long period despite short select, R3 repeats.
        push(1'b1, k0 + ST, "R11");
        push(1'b0, k0 + ST + LG, "R5");
        push(1'b1, k0 + 2*ST + LG, "R3");
        push(1'b0, k0 + 2*ST + 2*LG, "R3");
        push(1'b1, k0 + 3*ST + 2*LG, "R3");
        // R4: a service enables the short period.
        t = k0 + 3*ST + 2*LG;
        until_tick(t);
        service = 1'b1;
        push(1'b0, t + SH, "R4");
        push(1'b1, t + SH + ST, "R3");
        until_tick(t + 2);
        service = 1'b0;
        // R6: a service during reset does not shorten it.
        f = t + SH;
        until_tick(f + 1);
        service = 1'b1;
        until_tick(f + 2);
        service = 1'b0;
        r = f + ST;
        push(1'b0, r + LG, "R5");
        push(1'b1, r + LG + ST, "R3");
        // R6: repeated rising edges keep reset off; falling edges do not restart.
        r2 = r + LG + ST;
        for (int i = 0; i < 5; i++) begin
            until_tick(r2 + 3*i);
            service = 1'b1;
            until_tick(r2 + 3*i + 1);
            service = 1'b0;
        end
        push(1'b0, r2 + 12 + SH, "R6");
        push(1'b1, r2 + 12 + SH + ST, "R3");
        // R1 / R2 / R8 / R9: low-supply fault held longer than the stretch.
        r3 = r2 + 12 + SH + ST;
        until_tick(r3);
        supply_low = 1'b1;
        cs_n = 1'b0;
        push(1'b0, r3, "R1");
        repeat (4) @(negedge clk);
        chk(supply_good == 1'b0, "R9", "supply_good in fault", int'(supply_good), 0);
        chk(cs_n_gated == 1'b1, "R8", "cs blocked in fault", int'(cs_n_gated), 1);
        chk(backup == 1'b0, "R10", "backup with low supply only", int'(backup), 0);
        until_tick(r3 + 8);
        supply_low = 1'b0;
        push(1'b1, r3 + 8 + ST, "R2");
        repeat (4) @(negedge clk);
        chk(supply_good == 1'b1, "R9", "supply_good recovered", int'(supply_good), 1);
        chk(cs_n_gated == 1'b0, "R8", "cs follows low", int'(cs_n_gated), 0);
        cs_n = 1'b1;
        #1;
        chk(cs_n_gated == 1'b1, "R8", "cs follows high", int'(cs_n_gated), 1);
        cs_n = 1'b0;
        // R10 / R1 / R2: supply below battery.
        r4 = r3 + 8 + ST;
        until_tick(r4 + 2);
        below_batt = 1'b1;
        push(1'b0, r4 + 2, "R1");
        repeat (4) @(negedge clk);
        chk(backup == 1'b1, "R10", "backup on battery", int'(backup), 1);
        chk(supply_good == 1'b0, "R9", "supply_good on battery", int'(supply_good), 0);
        chk(cs_n_gated == 1'b1, "R8", "cs blocked on battery", int'(cs_n_gated), 1);
        until_tick(r4 + 4);
        below_batt = 1'b0;
        push(1'b1, r4 + 4 + ST, "R2");
        repeat (4) @(negedge clk);
        chk(backup == 1'b0, "R10", "backup released", int'(backup), 0);
        // R5: after a supply reset the long period applies again.
        r5 = r4 + 4 + ST;
        push(1'b0, r5 + LG, "R5");
        until_tick(r5 + LG + 2);
        chk(exp_q.size() == 0, "R3", "edges left in scoreboard", exp_q.size(), 0);
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule